// File: doc/BRIEF.md
# Memory-to-Stream Descriptor Walker

The walker is the transmit half of a scatter-gather DMA engine. Once started, it follows a linked list of descriptors held in memory. For each descriptor it fetches the fields it needs through a single-word memory port and reads the referenced buffer one word at a time. The bytes leave on a streaming data output. When a descriptor opens a packet, the five application words it carries are first sent on a separate control stream. After the buffer has been streamed, the walker writes a completion status back into the descriptor, reports the next pointer, and moves on. It stops at the tail descriptor, or earlier if it meets a descriptor that is already marked complete.

The control and status register file lives outside this block. It supplies the run and idle state, a start pulse, the head pointer and the tail pointer. It receives one-cycle pulses that set its halted and idle flags, the updated current pointer, and a packet-complete pulse meant for interrupt coalescing. Buffers must start on a word boundary. Lengths are counted in bytes.

Top module: `mm2s_walker`

## Requirements
- R1: A walk starts only on a `start_i` pulse seen while `run_i` is 1 and `idle_i` is 0. A pulse under any other condition issues no memory request and produces no pointer update.
- R2: Each descriptor is 64 bytes, little-endian, at byte address D. The next pointer is at D+0, the buffer address at D+8, the control word at D+24, the status word at D+28 and the application words at D+32 to D+48. Only the low 32 bits of each 64-bit pointer are used, and the reserved bytes are never read.
- R3: If a fetched status word already has bit 31 set, `halted_set_o` pulses and the walk ends. Nothing is streamed, the status is not rewritten and the pointer is not updated.
- R4: When control bit 27 (start of packet) is set, the five application words leave on the control stream in address order before any data beat of that descriptor. `ctl_tlast_o` is 1 on the fifth word, and the words hold steady while `ctl_tready_i` is 0.
- R5: Control bits 22:0 give the length L. The walker sends ceil(L/4) data beats, where beat k carries the word at buffer+4k with byte 0 in bits 7:0. `dat_tkeep_o` is 4'b1111, except on the final beat when L mod 4 is n > 0; that beat carries the low n lanes set. A length of 0 sends no beats.
- R6: `dat_tlast_o` is 1 only on the final beat of a descriptor whose control bit 26 (end of packet) is set. `pkt_done_o` pulses once, in the cycle after that beat is accepted.
- R7: While `dat_tvalid_o` is 1 and `dat_tready_i` is 0, the data, keep, last and valid outputs hold their values, so no data is lost.
- R8: After its data, each processed descriptor has the value L with bit 31 set written to D+28.
- R9: After the writeback, `cur_upd_o` pulses with `cur_nxt_o` equal to the next pointer. If D equals `tail_i`, `idle_set_o` pulses in the same cycle and the walk ends; otherwise the next descriptor is fetched.
- R10: At most one memory read is outstanding: no request is issued between an accepted read and its response.
- R11: After reset, all valid, request and pulse outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run state from the register file |
| idle_i | input | 1 | Idle state from the register file |
| start_i | input | 1 | Start pulse (tail pointer written) |
| cur_i | input | ADDR_W | Descriptor address to begin from |
| tail_i | input | ADDR_W | Tail descriptor address |
| cur_nxt_o | output | ADDR_W | Updated current descriptor pointer |
| cur_upd_o | output | 1 | Pulse: `cur_nxt_o` is new |
| halted_set_o | output | 1 | Pulse: set halted |
| idle_set_o | output | 1 | Pulse: set idle |
| pkt_done_o | output | 1 | Pulse: a packet finished |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| dat_tdata_o | output | 32 | Data stream payload |
| dat_tkeep_o | output | 4 | Data stream byte enables |
| dat_tlast_o | output | 1 | Data stream end of packet |
| dat_tvalid_o | output | 1 | Data stream valid |
| dat_tready_i | input | 1 | Data stream ready |
| ctl_tdata_o | output | 32 | Control stream word |
| ctl_tlast_o | output | 1 | Control stream last word |
| ctl_tvalid_o | output | 1 | Control stream valid |
| ctl_tready_i | input | 1 | Control stream ready |

## Verification
The bench builds descriptor chains whose lengths fall on and off word boundaries. Some chains have start and end of packet on different descriptors, some have a single descriptor that is both head and tail, and some have a pre-completed descriptor in the middle. It fills the unused pointer halves and the reserved words with noise.

Each failure mode shows up differently:
- A walker that tested completion after streaming would emit data before halting.
- A wrong lane mask would corrupt the last beat of odd lengths.
- Marking every end of descriptor as end of packet would split packets.
- Comparing the tail against the next pointer instead of the current one would stop one descriptor early.

Random back-pressure on both streams and on the memory port exposes outputs that drift during a stall and any second read issued too early.

// File: rtl/walker_pkg.sv
package walker_pkg;
  localparam int WORD_W   = 32;
  localparam int APP_N    = 5;
  localparam int LEN_W    = 23;
  localparam int SOF_BIT  = 27;
  localparam int EOF_BIT  = 26;
  localparam int DONE_BIT = 31;
  localparam int STEP_W   = 4;

  // descriptor word offsets (byte offset / 4)
  localparam int W_NEXT = 0;
  localparam int W_BUF  = 2;
  localparam int W_CTRL = 6;
  localparam int W_STAT = 7;
  localparam int W_APP  = 8;

  // fetch order: status first so a completed descriptor is rejected early
  localparam logic [STEP_W-1:0] STEP_STAT = 4'd0;
  localparam logic [STEP_W-1:0] STEP_CTRL = 4'd1;
  localparam logic [STEP_W-1:0] STEP_NEXT = 4'd2;
  localparam logic [STEP_W-1:0] STEP_BUF  = 4'd3;
  localparam logic [STEP_W-1:0] STEP_APP0 = 4'd4;
  localparam logic [STEP_W-1:0] STEP_APPL = STEP_APP0 + STEP_W'(APP_N - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_FREQ, ST_FWAIT, ST_CTRL, ST_DREQ,
    ST_DWAIT, ST_DOUT, ST_WB, ST_ADV
  } walk_st_t;

  function automatic logic [7:0] fetch_word(input logic [STEP_W-1:0] s);
    case (s)
      STEP_STAT: return 8'(W_STAT);
      STEP_CTRL: return 8'(W_CTRL);
      STEP_NEXT: return 8'(W_NEXT);
      STEP_BUF:  return 8'(W_BUF);
      default:   return 8'(W_APP) + 8'(s - STEP_APP0);
    endcase
  endfunction
endpackage

// File: rtl/walker_lane_mask.sv
module walker_lane_mask #(
  parameter int KEEP_W = 4,
  localparam int SH = $clog2(KEEP_W)
) (
  input  logic [SH-1:0]     rem_i,
  input  logic              last_i,
  output logic [KEEP_W-1:0] keep_o
);
  always_comb begin
    keep_o = '1;
    if (last_i && rem_i != '0) begin
      for (int i = 0; i < KEEP_W; i++) keep_o[i] = (i < int'(rem_i));
    end
  end
endmodule

// File: rtl/walker_beat_reg.sv
module walker_beat_reg #(
  parameter int W = 32,
  parameter int KEEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [W-1:0]      data_i,
  input  logic [KEEP_W-1:0] keep_i,
  input  logic              last_i,
  output logic [W-1:0]      tdata_o,
  output logic [KEEP_W-1:0] tkeep_o,
  output logic              tlast_o,
  output logic              tvalid_o,
  input  logic              tready_i,
  output logic              taken_o
);
  assign taken_o = tvalid_o && tready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tvalid_o <= 1'b0;
      tdata_o  <= '0;
      tkeep_o  <= '0;
      tlast_o  <= 1'b0;
    end else if (load_i) begin
      tvalid_o <= 1'b1;
      tdata_o  <= data_i;
      tkeep_o  <= keep_i;
      tlast_o  <= last_i;
    end else if (taken_o) begin
      tvalid_o <= 1'b0;
    end
  end

  // R7: a stalled beat keeps every field
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tkeep_o) && $stable(tlast_o)));
endmodule

// File: rtl/walker_app_stream.sv
module walker_app_stream #(
  parameter int N = 5,
  parameter int W = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          go_i,
  output logic [W-1:0]  tdata_o,
  output logic          tlast_o,
  output logic          tvalid_o,
  input  logic          tready_i,
  output logic          done_o
);
  logic [W-1:0]  words [N];
  logic [IW-1:0] rd_idx;
  logic          last_word;

  always_ff @(posedge clk) begin
    if (wr_i) words[wr_idx_i] <= wr_data_i;
  end

  assign last_word = (rd_idx == IW'(N - 1));
  assign tdata_o   = words[rd_idx];
  assign tlast_o   = last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      tvalid_o <= 1'b0;
      rd_idx   <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        tvalid_o <= 1'b1;
        rd_idx   <= '0;
      end else if (tvalid_o && tready_i) begin
        if (last_word) begin
          tvalid_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          rd_idx <= rd_idx + 1'b1;
        end
      end
    end
  end

  // R4: control word stays put while the sink is not ready
  p_ctrl_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (tvalid_o && !tready_i) |=> (tvalid_o && $stable(tdata_o) && $stable(tlast_o)));
endmodule

// File: rtl/mm2s_walker.sv
module mm2s_walker
  import walker_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] tail_i,
  output logic [ADDR_W-1:0] cur_nxt_o,
  output logic              cur_upd_o,
  output logic              halted_set_o,
  output logic              idle_set_o,
  output logic              pkt_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic [31:0]       dat_tdata_o,
  output logic [3:0]        dat_tkeep_o,
  output logic              dat_tlast_o,
  output logic              dat_tvalid_o,
  input  logic              dat_tready_i,
  output logic [31:0]       ctl_tdata_o,
  output logic              ctl_tlast_o,
  output logic              ctl_tvalid_o,
  input  logic              ctl_tready_i
);
  localparam int KEEP_W = WORD_W / 8;
  localparam int LANE_SH = $clog2(KEEP_W);
  localparam int BEAT_W = LEN_W - LANE_SH + 1;
  localparam int APP_IW = (APP_N > 1) ? $clog2(APP_N) : 1;

  walk_st_t          st;
  logic [ADDR_W-1:0] cur, nxt, bufa;
  logic [LEN_W-1:0]  len;
  logic              sof, eof;
  logic [STEP_W-1:0] step;
  logic [BEAT_W-1:0] widx, nbeats;
  logic              last_beat, rd_pending;
  logic [KEEP_W-1:0] keep_w;
  logic              beat_load, beat_taken;
  logic              app_wr, app_go, app_done;
  logic [WORD_W-1:0] stat_word;

  assign nbeats    = BEAT_W'(({1'b0, len} + (LEN_W + 1)'(KEEP_W - 1)) >> LANE_SH);
  assign last_beat = (widx == nbeats - 1'b1);

  // memory request port
  assign mem_req_o = (st == ST_FREQ) || (st == ST_DREQ) || (st == ST_WB);
  assign mem_we_o  = (st == ST_WB);
  always_comb begin
    case (st)
      ST_DREQ: mem_addr_o = bufa + ADDR_W'({widx, 2'b00});
      ST_WB:   mem_addr_o = cur + ADDR_W'(W_STAT * 4);
      default: mem_addr_o = cur + ADDR_W'({fetch_word(step), 2'b00});
    endcase
  end
  always_comb begin
    stat_word = '0;
    stat_word[LEN_W-1:0] = len;
    stat_word[DONE_BIT] = 1'b1;
  end
  assign mem_wdata_o = stat_word;

  // data beat path
  walker_lane_mask #(.KEEP_W(KEEP_W)) u_mask (
    .rem_i  (len[LANE_SH-1:0]),
    .last_i (last_beat),
    .keep_o (keep_w)
  );

  assign beat_load = (st == ST_DWAIT) && mem_rvalid_i;

  walker_beat_reg #(.W(WORD_W), .KEEP_W(KEEP_W)) u_beat (
    .clk      (clk),
    .rst      (rst),
    .load_i   (beat_load),
    .data_i   (mem_rdata_i),
    .keep_i   (keep_w),
    .last_i   (last_beat && eof),
    .tdata_o  (dat_tdata_o),
    .tkeep_o  (dat_tkeep_o),
    .tlast_o  (dat_tlast_o),
    .tvalid_o (dat_tvalid_o),
    .tready_i (dat_tready_i),
    .taken_o  (beat_taken)
  );

  // application word path
  assign app_wr = (st == ST_FWAIT) && mem_rvalid_i && (step >= STEP_APP0);
  assign app_go = app_wr && (step == STEP_APPL);

  walker_app_stream #(.N(APP_N), .W(WORD_W)) u_app (
    .clk       (clk),
    .rst       (rst),
    .wr_i      (app_wr),
    .wr_idx_i  (APP_IW'(step - STEP_APP0)),
    .wr_data_i (mem_rdata_i),
    .go_i      (app_go),
    .tdata_o   (ctl_tdata_o),
    .tlast_o   (ctl_tlast_o),
    .tvalid_o  (ctl_tvalid_o),
    .tready_i  (ctl_tready_i),
    .done_o    (app_done)
  );

  // walker state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cur          <= '0;
      nxt          <= '0;
      bufa         <= '0;
      len          <= '0;
      sof          <= 1'b0;
      eof          <= 1'b0;
      step         <= STEP_STAT;
      widx         <= '0;
      cur_nxt_o    <= '0;
      cur_upd_o    <= 1'b0;
      halted_set_o <= 1'b0;
      idle_set_o   <= 1'b0;
      pkt_done_o   <= 1'b0;
    end else begin
      cur_upd_o    <= 1'b0;
      halted_set_o <= 1'b0;
      idle_set_o   <= 1'b0;
      pkt_done_o   <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i && run_i && !idle_i) begin
            cur  <= cur_i;
            step <= STEP_STAT;
            st   <= ST_FREQ;
          end
        end
        ST_FREQ: if (mem_ready_i) st <= ST_FWAIT;
        ST_FWAIT: begin
          if (mem_rvalid_i) begin
            case (step)
              STEP_STAT: begin
                if (mem_rdata_i[DONE_BIT]) begin
                  halted_set_o <= 1'b1;
                  st <= ST_IDLE;
                end else begin
                  step <= STEP_CTRL;
                  st <= ST_FREQ;
                end
              end
              STEP_CTRL: begin
                len  <= mem_rdata_i[LEN_W-1:0];
                sof  <= mem_rdata_i[SOF_BIT];
                eof  <= mem_rdata_i[EOF_BIT];
                step <= STEP_NEXT;
                st   <= ST_FREQ;
              end
              STEP_NEXT: begin
                nxt  <= ADDR_W'(mem_rdata_i);
                step <= STEP_BUF;
                st   <= ST_FREQ;
              end
              STEP_BUF: begin
                bufa <= ADDR_W'(mem_rdata_i);
                widx <= '0;
                if (sof) begin
                  step <= STEP_APP0;
                  st   <= ST_FREQ;
                end else begin
                  st <= (len == '0) ? ST_WB : ST_DREQ;
                end
              end
              default: begin
                if (step == STEP_APPL) begin
                  st <= ST_CTRL;
                end else begin
                  step <= step + 1'b1;
                  st   <= ST_FREQ;
                end
              end
            endcase
          end
        end
        ST_CTRL: if (app_done) st <= (len == '0) ? ST_WB : ST_DREQ;
        ST_DREQ: if (mem_ready_i) st <= ST_DWAIT;
        ST_DWAIT: if (mem_rvalid_i) st <= ST_DOUT;
        ST_DOUT: begin
          if (beat_taken) begin
            if (last_beat) begin
              pkt_done_o <= eof;
              st <= ST_WB;
            end else begin
              widx <= widx + 1'b1;
              st <= ST_DREQ;
            end
          end
        end
        ST_WB: if (mem_ready_i) st <= ST_ADV;
        ST_ADV: begin
          cur_nxt_o <= nxt;
          cur_upd_o <= 1'b1;
          cur       <= nxt;
          if (cur == tail_i) begin
            idle_set_o <= 1'b1;
            st <= ST_IDLE;
          end else begin
            step <= STEP_STAT;
            st <= ST_FREQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // outstanding read tracker, used by the checks below
  always_ff @(posedge clk) begin
    if (rst) rd_pending <= 1'b0;
    else if (mem_req_o && !mem_we_o && mem_ready_i) rd_pending <= 1'b1;
    else if (mem_rvalid_i) rd_pending <= 1'b0;
  end

  p_single_read_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> !rd_pending);

  p_start_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !(run_i && !idle_i)) |=> (st == ST_IDLE));

  p_pkt_after_last_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_done_o |-> $past(dat_tvalid_o && dat_tready_i && dat_tlast_o));

  p_idle_with_upd_r9: assert property (@(posedge clk) disable iff (rst)
    idle_set_o |-> cur_upd_o);

  p_halt_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    halted_set_o |-> (!cur_upd_o && !dat_tvalid_o && !idle_set_o));
endmodule

// File: tb/mm2s_walker_test.sv
module mm2s_walker_test;
  logic clk = 0, rst = 1;
  logic run_i = 0, idle_i = 0, start_i = 0;
  logic [31:0] cur_i = 0, tail_i = 0, cur_nxt_o;
  logic cur_upd_o, halted_set_o, idle_set_o, pkt_done_o;
  logic mem_req_o, mem_we_o, mem_ready_i = 0, mem_rvalid_i = 0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = 0;
  logic [31:0] dat_tdata_o, ctl_tdata_o;
  logic [3:0] dat_tkeep_o;
  logic dat_tlast_o, dat_tvalid_o, dat_tready_i = 0;
  logic ctl_tlast_o, ctl_tvalid_o, ctl_tready_i = 0;

  mm2s_walker uut (.*);

  always #4 clk = ~clk;

  typedef struct packed {logic ch; logic [31:0] d; logic [3:0] k; logic l;} ev_t;
  ev_t exp_q[$];
  int unsigned stat_a[$], stat_v[$];
  logic [31:0] mem [0:1023];
  int errors = 0, checks = 0;
  int cnt_idle, cnt_halt, cnt_pkt, cnt_upd, req_cycles, overlap;
  int exp_idle, exp_halt, exp_pkt, exp_upd;
  logic [31:0] exp_cur, last_cur = 0;
  int rd_cnt = 0; logic [31:0] rd_buf;
  bit stall = 0, prev_stall = 0;
  logic [37:0] stall_val;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic see_event(input ev_t e);
    ev_t x;
    if (exp_q.size() == 0) begin
      chk(0, e.ch ? "R4 unexpected control word" : "R5 unexpected data beat", e, 0);
    end else begin
      x = exp_q.pop_front();
      if (x.ch) chk(e == x, "R4 control word", e, x);
      else begin
        chk(e.ch == 0 && e.d == x.d && e.k == x.k, "R5 data beat/keep", e, x);
        chk(e.l == x.l, "R6 tlast", e.l, x.l);
      end
    end
  endtask

  // environment: memory model, stream sinks, observers (all at negedge)
  initial begin
    forever begin
      @(negedge clk);
      mem_rvalid_i = 0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin mem_rvalid_i = 1; mem_rdata_i = rd_buf; end
      end
      if (!rst && prev_stall)
        chk(dat_tvalid_o && {dat_tdata_o, dat_tkeep_o, dat_tlast_o, 1'b1} == stall_val,
            "R7 stalled beat held", {dat_tdata_o, dat_tkeep_o, dat_tlast_o, dat_tvalid_o}, stall_val);
      dat_tready_i = stall ? ($urandom % 3 != 0) : 1'b1;
      ctl_tready_i = stall ? ($urandom % 3 != 0) : 1'b1;
      mem_ready_i  = stall ? ($urandom % 2 != 0) : 1'b1;
      prev_stall = !rst && dat_tvalid_o && !dat_tready_i;
      stall_val = {dat_tdata_o, dat_tkeep_o, dat_tlast_o, 1'b1};
      if (!rst && dat_tvalid_o && dat_tready_i) see_event({1'b0, dat_tdata_o, dat_tkeep_o, dat_tlast_o});
      if (!rst && ctl_tvalid_o && ctl_tready_i) see_event({1'b1, ctl_tdata_o, 4'hF, ctl_tlast_o});
      if (!rst && mem_req_o) begin
        req_cycles++;
        if (!mem_we_o && (rd_cnt > 0 || mem_rvalid_i)) overlap++;
        if (mem_ready_i) begin
          if (mem_we_o) mem[mem_addr_o[11:2]] = mem_wdata_o;
          else begin rd_buf = mem[mem_addr_o[11:2]]; rd_cnt = 1 + $urandom % 3; end
        end
      end
      if (!rst) begin
        cnt_idle += idle_set_o; cnt_halt += halted_set_o; cnt_pkt += pkt_done_o;
        if (cur_upd_o) begin cnt_upd++; last_cur = cur_nxt_o; end
      end
    end
  end

  // descriptor i at 64*i, its buffer at 0x400 + 64*i
  task automatic put_desc(input int i, input int nx, input int len, input bit s, input bit e, input bit done);
    int d = 16 * i;
    mem[d + 0] = 64 * nx; mem[d + 1] = $urandom;
    mem[d + 2] = 32'h400 + 64 * i; mem[d + 3] = $urandom;
    mem[d + 4] = $urandom; mem[d + 5] = $urandom;
    mem[d + 6] = {4'($urandom), s, e, 3'($urandom), 23'(len)};
    mem[d + 7] = done ? 32'h8000_0000 | $urandom : {1'b0, 31'($urandom)};
    for (int k = 0; k < 5; k++) mem[d + 8 + k] = $urandom;
    for (int k = 0; k < 16; k++) mem[256 + 16 * i + k] = $urandom;
  endtask

  task automatic build_expect(input logic [31:0] head, input logic [31:0] tail);
    logic [31:0] d = head, c, st, ba;
    int len, nb;
    exp_q.delete(); stat_a.delete(); stat_v.delete();
    exp_idle = 0; exp_halt = 0; exp_pkt = 0; exp_upd = 0; exp_cur = last_cur;
    for (int g = 0; g < 32; g++) begin
      st = mem[(d + 28) >> 2];
      if (st[31]) begin exp_halt = 1; stat_a.push_back(d + 28); stat_v.push_back(st); break; end
      c = mem[(d + 24) >> 2]; ba = mem[(d + 8) >> 2];
      len = c[22:0]; nb = (len + 3) / 4;
      if (c[27]) for (int k = 0; k < 5; k++) exp_q.push_back({1'b1, mem[(d + 32) / 4 + k], 4'hF, k == 4});
      for (int b = 0; b < nb; b++)
        exp_q.push_back({1'b0, mem[(ba >> 2) + b],
                         (b == nb - 1 && len % 4 != 0) ? 4'((1 << (len % 4)) - 1) : 4'hF,
                         (b == nb - 1) && c[26]});
      if (c[26] && nb > 0) exp_pkt++;
      stat_a.push_back(d + 28); stat_v.push_back(32'h8000_0000 | len);
      exp_upd++; exp_cur = mem[d >> 2];
      if (d == tail) begin exp_idle = 1; break; end
      d = mem[d >> 2];
    end
  endtask

  task automatic walk(input logic [31:0] head, input logic [31:0] tail, input bit stl, input string nm);
    build_expect(head, tail);
    stall = stl;
    cnt_idle = 0; cnt_halt = 0; cnt_pkt = 0; cnt_upd = 0; overlap = 0;
    @(negedge clk); run_i = 1; idle_i = 0; cur_i = head; tail_i = tail; start_i = 1;
    @(negedge clk); start_i = 0;
    for (int t = 0; t < 20000 && cnt_idle + cnt_halt == 0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {"R4/R5 all events seen ", nm}, exp_q.size(), 0);
    chk(cnt_halt == exp_halt, {"R3 halted pulses ", nm}, cnt_halt, exp_halt);
    chk(cnt_idle == exp_idle, {"R9 idle pulses ", nm}, cnt_idle, exp_idle);
    chk(cnt_pkt == exp_pkt, {"R6 packet pulses ", nm}, cnt_pkt, exp_pkt);
    chk(cnt_upd == exp_upd, {"R9 pointer updates ", nm}, cnt_upd, exp_upd);
    chk(last_cur == exp_cur, {"R9 final pointer ", nm}, last_cur, exp_cur);
    chk(overlap == 0, {"R10 single outstanding read ", nm}, overlap, 0);
    foreach (stat_a[i])
      chk(mem[stat_a[i] >> 2] == stat_v[i], {"R8/R3 status writeback ", nm}, mem[stat_a[i] >> 2], stat_v[i]);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(!dat_tvalid_o && !ctl_tvalid_o && !mem_req_o, "R11 valids low", {dat_tvalid_o, ctl_tvalid_o, mem_req_o}, 0);
    chk(!cur_upd_o && !halted_set_o && !idle_set_o && !pkt_done_o, "R11 pulses low",
        {cur_upd_o, halted_set_o, idle_set_o, pkt_done_o}, 0);

    // R1: start ignored when not running, or when already idle
    put_desc(0, 1, 8, 1, 1, 0);
    req_cycles = 0; cnt_upd = 0;
    run_i = 0; idle_i = 0; cur_i = 0; tail_i = 0; start_i = 1;
    @(negedge clk); start_i = 0; repeat (20) @(negedge clk);
    chk(req_cycles == 0 && cnt_upd == 0, "R1 start ignored while stopped", req_cycles, 0);
    run_i = 1; idle_i = 1; start_i = 1;
    @(negedge clk); start_i = 0; repeat (20) @(negedge clk);
    chk(req_cycles == 0 && cnt_upd == 0, "R1 start ignored while idle", req_cycles, 0);
    chk(!dat_tvalid_o && !ctl_tvalid_o, "R1 no stream output", {dat_tvalid_o, ctl_tvalid_o}, 0);

    // directed: packet split over two descriptors, then a 5-byte single-descriptor packet (R2 R5 R6)
    put_desc(0, 1, 10, 1, 0, 0);
    put_desc(1, 2, 8, 0, 1, 0);
    put_desc(2, 7, 5, 1, 1, 0);
    walk(0, 128, 0, "three-desc chain");

    // directed: head equals tail, word-multiple length, back-pressure
    put_desc(3, 5, 4, 1, 1, 0);
    walk(192, 192, 1, "single desc");

    // directed: completed descriptor mid-chain halts the walk (R3)
    put_desc(0, 1, 6, 1, 0, 0);
    put_desc(1, 2, 7, 0, 1, 1);
    put_desc(2, 3, 3, 1, 1, 0);
    walk(0, 128, 0, "halt mid-chain");

    // directed: already-complete head descriptor
    put_desc(4, 5, 12, 1, 1, 1);
    walk(256, 256, 1, "halt at head");

    // random chains under random back-pressure
    for (int r = 0; r < 12; r++) begin
      int n = 1 + $urandom % 6;
      int hidx = ($urandom % 4 == 0) ? $urandom % n : -1;
      for (int i = 0; i < n; i++)
        put_desc(i, i + 1, 1 + $urandom % 64, $urandom % 2, $urandom % 2, i == hidx);
      walk(0, 64 * (n - 1), $urandom % 2, $sformatf("random run %0d", r));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule